// File: doc/BRIEF.md
# Password-Guarded Watchdog and Interval Timer

This block watches for a stalled program. A counter advances on rising edges of one of four slow clock inputs. Each input is synchronised into the bus clock domain and turned into a one-cycle tick. When the counter reaches the selected interval, the block acts according to its mode. In watchdog mode it requests a reset. In interval mode it raises an interrupt pending flag. Software must keep writing the control register to clear the counter before it expires.

Every control write carries a key byte. A write with the wrong key never changes the register. In watchdog mode such a write requests a reset, exactly as an expiry does. A static routing input sends the reset request to either a hard-reset output or a soft-reset output. A sticky cause flag records that the watchdog issued the request. The flag survives the system reset (`rst_n`), is cleared only by power-on reset (`por_n`) or by an explicit clear, and lets boot code identify a watchdog reset.

Top module: `wdt_guard`

## Requirements
- R1: After reset the control register reads 16'h6907. This means run, source 0, watchdog mode and interval code 7. All request outputs and `irq_pend` are 0, and after power-on reset `cause_flag` is 0.
- R2: A write whose upper byte is 8'h5A loads the lower byte. The lower byte is laid out as follows: bit 7 hold, bits 6:5 source select, bit 4 mode (0 = watchdog, 1 = interval), bit 3 clear, bits 2:0 interval code. Reads always return 8'h69 in the upper byte, and bit 3 always reads 0.
- R3: A write with any other upper byte leaves the register unchanged. In watchdog mode it produces a one-cycle reset request in the cycle after the write.
- R4: In watchdog mode, the 2^N-th counted rising edge of the selected source produces exactly one one-cycle reset request. N is 6, 9, 13, 15, 19, 23, 27 or 31 for interval codes 0 to 7, and the count then restarts from zero.
- R5: With `rst_route` = 0 the request appears on `hard_rst_req`, and with `rst_route` = 1 it appears on `soft_rst_req`. The two outputs are never high together.
- R6: `cause_flag` is set with every reset request. It holds through `rst_n` and is cleared by `cause_clr` or `por_n`.
- R7: In interval mode, expiry sets `irq_pend` and produces no reset request. A wrong-key write in interval mode is ignored without a reset.
- R8: `irq_ack` clears `irq_pend`. An expiry in the same cycle as the acknowledge leaves the flag set.
- R9: Source select values 00, 01, 10 and 11 pick `src_clk[0]` to `src_clk[3]`. Edges on unselected inputs are not counted. Changing the select clears the counter.
- R10: While hold is 1, source edges are not counted. Writing 1 to the clear bit restarts the count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | System reset, active low |
| por_n | input | 1 | Power-on reset for the cause flag, active low |
| src_clk | input | 4 | Candidate counter clocks, asynchronous |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 16 | Write data: key byte above, fields below |
| rd_data | output | 16 | Read key byte and current fields |
| rst_route | input | 1 | 0 routes the reset to hard, 1 routes it to soft |
| hard_rst_req | output | 1 | Hard-reset request pulse |
| soft_rst_req | output | 1 | Soft-reset request pulse |
| cause_flag | output | 1 | Sticky flag showing the watchdog caused a reset |
| cause_clr | input | 1 | Clears the cause flag |
| irq_pend | output | 1 | Interval interrupt pending |
| irq_ack | input | 1 | Interrupt serviced acknowledge |

## Verification
A counter that has drifted by even one tick moves the request or interrupt one source period early or late. The bench therefore checks that the 2^N-1-th edge gives nothing and that the 2^N-th edge gives exactly one pulse. A wrong mode or routing state shows on the very next cycle as a pulse on the wrong output, or as a missing pulse. A register corrupted by a rejected write is visible at once on the read port. A cause flag lost across `rst_n` appears as soon as that reset is released.

// File: rtl/wdt_guard_pkg.sv
package wdt_guard_pkg;

   localparam int unsigned SEL_W = 2;

   typedef struct packed {
      logic             hold;
      logic [SEL_W-1:0] sel;
      logic             ivl;
      logic             clr;
      logic [2:0]       isel;
   } wdt_ctl_t;

   localparam wdt_ctl_t CTL_RESET = '{hold: 1'b0, sel: '0, ivl: 1'b0, clr: 1'b0, isel: 3'd7};

   function automatic logic [4:0] tap_bits(input logic [2:0] code);
      case (code)
         3'd0:    tap_bits = 5'd6;
         3'd1:    tap_bits = 5'd9;
         3'd2:    tap_bits = 5'd13;
         3'd3:    tap_bits = 5'd15;
         3'd4:    tap_bits = 5'd19;
         3'd5:    tap_bits = 5'd23;
         3'd6:    tap_bits = 5'd27;
         default: tap_bits = 5'd31;
      endcase
   endfunction

endpackage

// File: rtl/wdt_src_sync.sv
module wdt_src_sync #(
   parameter int unsigned STAGES    = 2,
   parameter bit          EDGE_RISE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic edge_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("wdt_src_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] sync_q;
   logic              last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         last_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], async_in};
         last_q <= sync_q[STAGES-1];
      end
   end

   generate
      if (EDGE_RISE) begin : g_rise
         assign edge_o = sync_q[STAGES-1] & ~last_q;
      end else begin : g_fall
         assign edge_o = ~sync_q[STAGES-1] & last_q;
      end
   endgenerate

   // R9
   single_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      edge_o |=> !edge_o);

endmodule

// File: rtl/wdt_ctl_reg.sv
module wdt_ctl_reg
   import wdt_guard_pkg::*;
#(
   parameter int unsigned     KEY_W  = 8,
   parameter logic [KEY_W-1:0] WR_KEY = 8'h5A,
   parameter logic [KEY_W-1:0] RD_KEY = 8'h69
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [KEY_W+7:0]     wr_data,
   output wdt_ctl_t             ctl,
   output logic [KEY_W+7:0]     rd_data,
   output logic                 bad_wr,
   output logic                 clr_req
);

   wdt_ctl_t wr_fields;
   logic     good_wr;

   assign wr_fields = wdt_ctl_t'(wr_data[7:0]);
   assign good_wr   = wr_en && (wr_data[KEY_W+7:8] == WR_KEY);
   assign bad_wr    = wr_en && !good_wr;
   assign clr_req   = good_wr && (wr_fields.clr || (wr_fields.sel != ctl.sel));
   assign rd_data   = {RD_KEY, ctl};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl <= CTL_RESET;
      end else if (good_wr) begin
         ctl     <= wr_fields;
         ctl.clr <= 1'b0;
      end
   end

   // R3
   bad_key_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bad_wr |=> $stable(ctl));

   // R2
   clear_not_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (good_wr && wr_fields.clr) |=> (rd_data[3] == 1'b0));

endmodule

// File: rtl/wdt_tick_counter.sv
module wdt_tick_counter
   import wdt_guard_pkg::*;
#(
   parameter int unsigned CNT_W = 32
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       hold,
   input  logic       clear,
   input  logic [2:0] isel,
   output logic       expire
);

   generate
      if (CNT_W < 32) begin : g_bad_width
         $error("wdt_tick_counter: CNT_W must cover the 2^31 tap");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] mask;
   logic             step;

   assign mask   = ~({CNT_W{1'b1}} << tap_bits(isel));
   assign step   = tick && !hold && !clear;
   assign expire = step && ((cnt & mask) == mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt <= '0;
      else if (clear)   cnt <= '0;
      else if (expire)  cnt <= '0;
      else if (step)    cnt <= cnt + CNT_W'(1);
   end

   // R10
   hold_freezes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hold && !clear) |=> $stable(cnt));

   // R4
   count_steps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !hold && !clear && !expire) |=> (cnt == $past(cnt) + CNT_W'(1)));

endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
   import wdt_guard_pkg::*;
#(
   parameter int unsigned      CNT_W       = 32,
   parameter int unsigned      KEY_W       = 8,
   parameter logic [KEY_W-1:0] WR_KEY      = 8'h5A,
   parameter logic [KEY_W-1:0] RD_KEY      = 8'h69,
   parameter int unsigned      SYNC_STAGES = 2,
   parameter bit               EDGE_RISE   = 1'b1,
   localparam int unsigned     NSRC        = 1 << SEL_W,
   localparam int unsigned     DW          = KEY_W + 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          por_n,
   input  logic [NSRC-1:0] src_clk,
   input  logic          wr_en,
   input  logic [DW-1:0] wr_data,
   output logic [DW-1:0] rd_data,
   input  logic          rst_route,
   output logic          hard_rst_req,
   output logic          soft_rst_req,
   output logic          cause_flag,
   input  logic          cause_clr,
   output logic          irq_pend,
   input  logic          irq_ack
);

   generate
      if (KEY_W < 1) begin : g_bad_key
         $error("wdt_guard: KEY_W must be positive");
      end
   endgenerate

   wdt_ctl_t        ctl;
   logic            bad_wr;
   logic            clr_req;
   logic [NSRC-1:0] src_edge;
   logic            tick;
   logic            expire;
   logic            wd_fire;

   wdt_ctl_reg #(.KEY_W(KEY_W), .WR_KEY(WR_KEY), .RD_KEY(RD_KEY)) ctl_i (
      .clk, .rst_n, .wr_en, .wr_data,
      .ctl, .rd_data, .bad_wr, .clr_req
   );

   for (genvar s = 0; s < NSRC; s++) begin : g_src
      wdt_src_sync #(.STAGES(SYNC_STAGES), .EDGE_RISE(EDGE_RISE)) sync_i (
         .clk, .rst_n, .async_in(src_clk[s]), .edge_o(src_edge[s])
      );
   end

   assign tick = src_edge[ctl.sel];

   wdt_tick_counter #(.CNT_W(CNT_W)) cnt_i (
      .clk, .rst_n, .tick, .hold(ctl.hold), .clear(clr_req),
      .isel(ctl.isel), .expire
   );

   assign wd_fire = !ctl.ivl && (expire || bad_wr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hard_rst_req <= 1'b0;
         soft_rst_req <= 1'b0;
         irq_pend     <= 1'b0;
      end else begin
         hard_rst_req <= wd_fire && !rst_route;
         soft_rst_req <= wd_fire &&  rst_route;
         if (ctl.ivl && expire) irq_pend <= 1'b1;
         else if (irq_ack)      irq_pend <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)         cause_flag <= 1'b0;
      else if (wd_fire)   cause_flag <= 1'b1;
      else if (cause_clr) cause_flag <= 1'b0;
   end

   // R5
   one_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(hard_rst_req && soft_rst_req));

   // R6
   cause_set_chk: assert property (@(posedge clk) disable iff (!por_n)
      (rst_n && wd_fire) |=> cause_flag);

   // R7
   ivl_no_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctl.ivl |=> !(hard_rst_req || soft_rst_req));

   // R8
   irq_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl.ivl && expire) |=> irq_pend);

endmodule

// File: tb/wdt_guard_tb_top.sv
module wdt_guard_tb_top;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        por_n = 1'b0;
   logic [3:0]  src_clk = '0;
   logic        wr_en = 1'b0;
   logic [15:0] wr_data = '0;
   logic [15:0] rd_data;
   logic        rst_route = 1'b0;
   logic        hard_rst_req, soft_rst_req, cause_flag, irq_pend;
   logic        cause_clr = 1'b0;
   logic        irq_ack = 1'b0;

   int n_tests = 0;
   int n_fail  = 0;
   int n_hard  = 0;
   int n_soft  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   wdt_guard dut_i (
      .clk, .rst_n, .por_n, .src_clk, .wr_en, .wr_data, .rd_data,
      .rst_route, .hard_rst_req, .soft_rst_req, .cause_flag, .cause_clr,
      .irq_pend, .irq_ack
   );

   always @(negedge clk) begin
      if (hard_rst_req) n_hard++;
      if (soft_rst_req) n_soft++;
   end

   // {write data, expected read, expected reset pulse}
   localparam logic [32:0] VEC [0:5] = '{
      {16'h5A87, 16'h6987, 1'b0},
      {16'h5A8B, 16'h6983, 1'b0},
      {16'h3300, 16'h6983, 1'b1},
      {16'h5AF0, 16'h69F0, 1'b0},
      {16'h1280, 16'h69F0, 1'b0},
      {16'h5AA2, 16'h69A2, 1'b0}
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic settle();
      repeat (3) @(negedge clk);
      #1;
   endtask

   task automatic ctl_write(input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1;
      wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      settle();
   endtask

   task automatic pulses(input int idx, input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) src_clk[idx] = 1'b1;
         @(negedge clk);
         @(negedge clk) src_clk[idx] = 1'b0;
         @(negedge clk);
      end
      settle();
   endtask

   task automatic zero_counts();
      n_hard = 0;
      n_soft = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      por_n = 1'b1;
      rst_n = 1'b1;
      settle();
      // R1 reset state
      check("R1 rd_data", rd_data, 32'h6907);
      check("R1 outputs", {hard_rst_req, soft_rst_req, irq_pend, cause_flag}, 0);

      // R2 / R3 / R7 register table
      for (int v = 0; v < 6; v++) begin
         zero_counts();
         ctl_write(VEC[v][32:17]);
         check("R2 R3 table read", rd_data, VEC[v][16:1]);
         check("R3 R7 table reset", n_hard, VEC[v][0]);
      end
      check("R6 flag after key fault", cause_flag, 1);
      @(negedge clk) cause_clr = 1'b1;
      @(negedge clk) cause_clr = 1'b0;
      #1;
      check("R6 explicit clear", cause_flag, 0);

      // R4 / R5 watchdog expiry on source 0, hard route
      ctl_write(16'h5A00);
      zero_counts();
      pulses(0, 63);
      check("R4 no expiry at 63", n_hard, 0);
      pulses(0, 1);
      check("R4 expiry at 64", n_hard, 1);
      check("R5 hard route only", n_soft, 0);

      // R9 source select, R5 soft route
      rst_route = 1'b1;
      ctl_write(16'h5A20);
      zero_counts();
      pulses(0, 70);
      check("R9 unselected ignored", n_soft + n_hard, 0);
      pulses(1, 63);
      check("R9 source1 at 63", n_soft, 0);
      pulses(1, 1);
      check("R5 soft route at 64", n_soft, 1);
      check("R5 no hard pulse", n_hard, 0);

      // R10 hold and clear
      ctl_write(16'h5AA0);
      zero_counts();
      pulses(1, 100);
      check("R10 hold stops count", n_soft, 0);
      ctl_write(16'h5A20);
      pulses(1, 40);
      ctl_write(16'h5A28);
      check("R10 clear bit reads 0", rd_data, 32'h6920);
      pulses(1, 63);
      check("R10 restart at 63", n_soft, 0);
      pulses(1, 1);
      check("R10 restart at 64", n_soft, 1);

      // R6 flag survives system reset, cleared by power-on
      check("R6 flag set", cause_flag, 1);
      @(negedge clk) rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      settle();
      check("R6 flag held over rst_n", cause_flag, 1);
      check("R1 register after rst_n", rd_data, 32'h6907);
      @(negedge clk) por_n = 1'b0;
      @(negedge clk) por_n = 1'b1;
      #1;
      check("R6 por clears flag", cause_flag, 0);

      // R7 / R8 interval mode
      zero_counts();
      ctl_write(16'h5A18);
      ctl_write(16'h0018);
      check("R7 bad key no change", rd_data, 32'h6910);
      check("R7 bad key no reset", n_soft + n_hard, 0);
      pulses(0, 63);
      check("R7 irq not yet", irq_pend, 0);
      pulses(0, 1);
      check("R7 irq at 64", irq_pend, 1);
      check("R7 no reset in interval", n_soft + n_hard, 0);
      check("R7 no cause flag", cause_flag, 0);
      pulses(0, 63);
      @(negedge clk) src_clk[0] = 1'b1;
      @(negedge clk);
      @(negedge clk) begin
         src_clk[0] = 1'b0;
         irq_ack = 1'b1;
      end
      @(negedge clk) irq_ack = 1'b0;
      #1;
      check("R8 expiry beats ack", irq_pend, 1);
      @(negedge clk) irq_ack = 1'b1;
      @(negedge clk) irq_ack = 1'b0;
      #1;
      check("R8 ack clears", irq_pend, 0);

      // R4 interval code 1 gives 2^9
      ctl_write(16'h5A19);
      pulses(0, 511);
      check("R4 code1 none at 511", irq_pend, 0);
      pulses(0, 1);
      check("R4 code1 at 512", irq_pend, 1);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule